// File: doc/BRIEF.md
# Five-Requester Prioritised Memory Bus Arbiter

This block shares one synchronous memory or peripheral port among five requesters of a split program/data bus: data write, program write, data read, program read and instruction fetch. In each cycle it looks at the requests that are present and grants exactly one of them, following a fixed priority. It then drives the shared port with the winner's address, write strobe and write data.

Program-side requesters carry narrower addresses than the data side. Their addresses are widened with zeros before they reach the shared port. Read data comes back from the port one cycle after the grant. It is returned with a tag that names the requester it belongs to.

A requester that loses holds its request, address and data until it is granted. Two pairs of requesters are never active together by system construction: the two writers, and the program reader with the fetcher.

Top module: `hv_bus_arb`

## Requirements
- R1: Grant bit positions are 0 data write, 1 program write, 2 data read, 3 program read and 4 instruction fetch. The granted requester is the lowest-numbered one that is requesting. A data write never occurs together with a program write, and a program read never occurs together with a fetch.
- R2: At most one grant bit is high in any cycle. With no request, no grant is high and `mem_en` is low; with any request, `mem_en` is high.
- R3: `mem_addr` carries the winner's address. `mem_we` is high exactly when the winner is a writer. `mem_wdata` carries the winning writer's data, and is zero when the winner is a reader.
- R4: Program write, program read and fetch addresses are PAW bits wide and reach `mem_addr` zero-extended to DAW bits.
- R5: In the cycle after a read grant, `rsp_valid` is high and `rsp_data` equals `mem_rdata`. `rsp_tag` gives the source code: 2 for data read, 3 for program read and 4 for fetch.
- R6: In the cycle after a write grant, or after a cycle with no grant, `rsp_valid` is low.
- R7: A requester that loses keeps its request, address and data stable, and is granted in the first cycle in which no higher-priority request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_d_req | input | 1 | Data write request |
| wr_d_addr | input | DAW | Data write address |
| wr_d_wdata | input | DW | Data write data |
| wr_p_req | input | 1 | Program write request |
| wr_p_addr | input | PAW | Program write address |
| wr_p_wdata | input | DW | Program write data |
| rd_d_req | input | 1 | Data read request |
| rd_d_addr | input | DAW | Data read address |
| rd_p_req | input | 1 | Program read request |
| rd_p_addr | input | PAW | Program read address |
| ft_req | input | 1 | Instruction fetch request |
| ft_addr | input | PAW | Fetch address |
| gnt | output | 5 | One-hot grant, with bit positions as in R1 |
| mem_en | output | 1 | Shared port access strobe |
| mem_we | output | 1 | Shared port write strobe |
| mem_addr | output | DAW | Shared port address |
| mem_wdata | output | DW | Shared port write data |
| mem_rdata | input | DW | Shared port read data, valid one cycle after a read access |
| rsp_valid | output | 1 | Read response valid |
| rsp_tag | output | 3 | Source code of the read response |
| rsp_data | output | DW | Read response data |

## Verification
The bench builds the block with its default widths: 22-bit program addresses, 32-bit data addresses and 32-bit data. Every program address the bench uses has its top bit set, so any sign extension or truncation shows up in the upper bits of `mem_addr`.

The bench starts each of the 18 legal request combinations together. It then retires the winner every cycle, the way a real requester would. This walks every drain order and every read/write interleaving, and checks the grants, the port fields and the tagged responses cycle by cycle.

// File: rtl/hv_bus_arb.sv
module hv_bus_arb #(
  parameter int PAW = 22,
  parameter int DAW = 32,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_d_req,
  input  logic [DAW-1:0] wr_d_addr,
  input  logic [DW-1:0]  wr_d_wdata,
  input  logic           wr_p_req,
  input  logic [PAW-1:0] wr_p_addr,
  input  logic [DW-1:0]  wr_p_wdata,
  input  logic           rd_d_req,
  input  logic [DAW-1:0] rd_d_addr,
  input  logic           rd_p_req,
  input  logic [PAW-1:0] rd_p_addr,
  input  logic           ft_req,
  input  logic [PAW-1:0] ft_addr,
  output logic [4:0]     gnt,
  output logic           mem_en,
  output logic           mem_we,
  output logic [DAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           rsp_valid,
  output logic [2:0]     rsp_tag,
  output logic [DW-1:0]  rsp_data
);
  localparam int PAD = DAW - PAW;

  logic [4:0] req;
  logic [2:0] win;

  assign req       = {ft_req, rd_p_req, rd_d_req, wr_p_req, wr_d_req};
  assign gnt       = req & (~req + 5'd1);
  assign mem_en    = |req;
  assign mem_we    = gnt[0] | gnt[1];
  assign mem_wdata = gnt[0] ? wr_d_wdata : gnt[1] ? wr_p_wdata : '0;

  always_comb begin
    win      = 3'd0;
    mem_addr = '0;
    unique case (1'b1)
      gnt[0]: begin win = 3'd0; mem_addr = wr_d_addr; end
      gnt[1]: begin win = 3'd1; mem_addr = {{PAD{1'b0}}, wr_p_addr}; end
      gnt[2]: begin win = 3'd2; mem_addr = rd_d_addr; end
      gnt[3]: begin win = 3'd3; mem_addr = {{PAD{1'b0}}, rd_p_addr}; end
      gnt[4]: begin win = 3'd4; mem_addr = {{PAD{1'b0}}, ft_addr}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_tag   <= 3'd0;
    end else begin
      rsp_valid <= |gnt[4:2];
      rsp_tag   <= win;
    end
  end

  assign rsp_data = mem_rdata;

  AST_NO_WR_PAIR:  assert property (@(posedge clk) disable iff (!rst_n) !(wr_d_req && wr_p_req));  // R1
  AST_NO_RD_PAIR:  assert property (@(posedge clk) disable iff (!rst_n) !(rd_p_req && ft_req));    // R1
  AST_ONE_GNT:     assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));            // R2
  AST_EN_MATCH:    assert property (@(posedge clk) disable iff (!rst_n) mem_en == (gnt != 5'd0));  // R2
  AST_ZEXT:        assert property (@(posedge clk) disable iff (!rst_n)
                     (gnt[1] || gnt[3] || gnt[4]) |-> mem_addr[DAW-1:PAW] == '0);                // R4
  AST_RSP_FETCH:   assert property (@(posedge clk) disable iff (!rst_n)
                     gnt[4] |=> (rsp_valid && rsp_tag == 3'd4));                                  // R5
  AST_RSP_DREAD:   assert property (@(posedge clk) disable iff (!rst_n)
                     gnt[2] |=> (rsp_valid && rsp_tag == 3'd2));                                  // R5
  AST_NO_RSP:      assert property (@(posedge clk) disable iff (!rst_n)
                     (gnt[4:2] == 3'b000) |=> !rsp_valid);                                        // R6
  AST_LOSER_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
                     (|(req & ~gnt)) |=> ((req & $past(req & ~gnt)) == $past(req & ~gnt)));      // R7
endmodule

// File: tb/hv_bus_arb_tb.sv
module hv_bus_arb_tb;
  localparam int PAW = 22;
  localparam int DAW = 32;
  localparam int DW  = 32;
  localparam logic [31:0] KEY = 32'h5A5A_C3C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_d_req = 0, wr_p_req = 0, rd_d_req = 0, rd_p_req = 0, ft_req = 0;
  logic [DAW-1:0] wr_d_addr = '0, rd_d_addr = '0;
  logic [PAW-1:0] wr_p_addr = '0, rd_p_addr = '0, ft_addr = '0;
  logic [DW-1:0]  wr_d_wdata = '0, wr_p_wdata = '0;
  logic [4:0]     gnt;
  logic           mem_en, mem_we, rsp_valid;
  logic [DAW-1:0] mem_addr;
  logic [DW-1:0]  mem_wdata, mem_rdata, rsp_data;
  logic [2:0]     rsp_tag;
  logic [DAW-1:0] raddr_q = '0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) if (mem_en && !mem_we) raddr_q <= mem_addr;
  assign mem_rdata = raddr_q ^ KEY;

  hv_bus_arb #(.PAW(PAW), .DAW(DAW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_d_req(wr_d_req), .wr_d_addr(wr_d_addr), .wr_d_wdata(wr_d_wdata),
    .wr_p_req(wr_p_req), .wr_p_addr(wr_p_addr), .wr_p_wdata(wr_p_wdata),
    .rd_d_req(rd_d_req), .rd_d_addr(rd_d_addr),
    .rd_p_req(rd_p_req), .rd_p_addr(rd_p_addr),
    .ft_req(ft_req), .ft_addr(ft_addr),
    .gnt(gnt), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  task automatic chk(input string req_id, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req_id, what, act, exp);
    end
  endtask

  function automatic logic [DAW-1:0] addr_of(input int code, input logic [4:0] combo);
    logic [PAW-1:0] p;
    p = {1'b1, 11'h3A5, 2'b00, combo, code[2:0]};
    if (code == 0 || code == 2) return {8'hD0 + code[7:0], 11'h155, 2'b00, combo, code[2:0]};
    return {{(DAW-PAW){1'b0}}, p};
  endfunction

  function automatic logic [DW-1:0] data_of(input int code, input logic [4:0] combo);
    return {16'hBEE0 + code[15:0], 11'd0, combo};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [4:0] pend;
    logic [4:0] exp_g;
    int         code;
    logic       exp_rv;
    logic [2:0] exp_tag;
    logic [DAW-1:0] exp_ra;
    repeat (3) @(negedge clk);
    #1;
    chk("R2", "reset gnt", gnt, 0);
    chk("R2", "reset mem_en", mem_en, 0);
    chk("R6", "reset rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6", "idle rsp_valid", rsp_valid, 0);

    for (int c = 0; c < 32; c++) begin
      logic [4:0] combo;
      combo = c[4:0];
      if (combo[0] && combo[1]) continue;
      if (combo[3] && combo[4]) continue;
      wr_d_addr  = addr_of(0, combo);
      wr_p_addr  = addr_of(1, combo)[PAW-1:0];
      rd_d_addr  = addr_of(2, combo);
      rd_p_addr  = addr_of(3, combo)[PAW-1:0];
      ft_addr    = addr_of(4, combo)[PAW-1:0];
      wr_d_wdata = data_of(0, combo);
      wr_p_wdata = data_of(1, combo);
      pend = combo;
      {ft_req, rd_p_req, rd_d_req, wr_p_req, wr_d_req} = pend;
      while (1) begin
        #1;
        exp_g = pend & (~pend + 5'd1);
        code = 0;
        for (int k = 0; k < 5; k++) if (exp_g[k]) code = k;
        chk("R1", "grant", gnt, exp_g);
        chk("R2", "mem_en", mem_en, pend != 0);
        if (pend != 0) begin
          chk("R3", "mem_we", mem_we, code < 2);
          chk(code == 1 || code >= 3 ? "R4" : "R3", "mem_addr", mem_addr, addr_of(code, combo));
          chk("R3", "mem_wdata", mem_wdata, code < 2 ? data_of(code, combo) : '0);
        end
        exp_rv  = (pend != 0) && code >= 2;
        exp_tag = code[2:0];
        exp_ra  = addr_of(code, combo);
        @(posedge clk);
        @(negedge clk);
        chk(exp_rv ? "R5" : "R6", "rsp_valid", rsp_valid, exp_rv);
        if (exp_rv) begin
          chk("R5", "rsp_tag", rsp_tag, exp_tag);
          chk("R5", "rsp_data", rsp_data, exp_ra ^ KEY);
        end
        if (pend == 0) break;
        // R7: losers stay asserted; only the winner retires
        pend = pend & ~exp_g;
        {ft_req, rd_p_req, rd_d_req, wr_p_req, wr_d_req} = pend;
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule